// File: doc/BRIEF.md
# Trigger event frame assembler

This block turns each trigger into one outgoing event frame on a 32-bit valid/ready stream. When a trigger is accepted it captures a free-running 64-bit timestamp and the node address. It then sends four header words. While the headers go out, it collects multisample records. Each record is 128 bits wide, is tagged with a buffer address, and is written into an internal word buffer. The buffer drains into the payload. The frame closes with a tail word that packs the count of multisamples sent, the count dropped and two error flags.

The sample source does not stall. A record that arrives when the buffer cannot take all four of its words is dropped as a whole and counted. The collection window opens the cycle after the trigger is accepted. It closes when the source raises an end strobe. The timestamp clears when a run starts and then advances by one every clock.

Top module: `evframe_asm`

## Requirements
- R1: While `rst_n` is low, and after it is released, `o_valid` stays low until a trigger is accepted.
- R2: The timestamp reads 0 in the cycle after `run_start` is sampled high and rises by one each cycle after that. Word 2 of a frame carries bits 31:0 of the timestamp held in the cycle the trigger was sampled. Word 3 carries bits 63:32.
- R3: Word 0 equals `hdr0_cfg` at the time of transfer. Word 1 is `{24'h0, node_addr}` as sampled with the trigger.
- R4: Each accepted multisample adds four payload words in arrival order. `s_ms[31:0]` goes out first and `s_ms[127:96]` last.
- R5: A frame has exactly 5 + 4*M words. `o_last` is high only on the final word, the tail. The cycle after the tail is taken, `o_valid` is low.
- R6: Tail bits 11:0 hold M, the number of multisamples placed in the payload.
- R7: A multisample that arrives while fewer than four word slots are free is dropped whole. Tail bits 23:12 count the drops. Tail bit 27 is set exactly when at least one drop happened.
- R8: The drop and sample counts saturate at 4095.
- R9: Tail bit 26 is set when any multisample in the window carried a buffer address different from the first one seen. This includes dropped multisamples.
- R10: Tail bits 31:28 and 25:24 are zero.
- R11: A trigger that arrives before the tail of the current frame has been taken is ignored. Multisamples and end strobes outside a collection window are ignored.
- R12: While `o_valid` is high and `o_ready` is low, the output word and `o_last` hold steady and `o_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_start | input | 1 | Clears the timestamp |
| trig | input | 1 | Trigger strobe, taken only when idle |
| node_addr | input | 8 | Node address placed in header word 1 |
| hdr0_cfg | input | 32 | Configured header word 0 |
| s_valid | input | 1 | A multisample record is present |
| s_ms | input | 128 | Multisample record, four 32-bit words |
| s_addr | input | AW | Buffer address tag of the record |
| s_end | input | 1 | Closes the collection window |
| o_valid | output | 1 | Output word valid |
| o_data | output | 32 | Output word |
| o_last | output | 1 | Marks the tail word |
| o_ready | input | 1 | Downstream accepts the word |

## Verification
A bad fill count or pointer shows up in the same frame. It appears as a payload word out of order, or as a payload length that disagrees with the M field in the tail. A collection flag that is stuck high or low shows up as a frame that never closes or closes too early. A counter or flag that is not cleared at a trigger carries stale drop counts or stale error bits into the next frame's tail. For that reason, frames with and without drops are run back to back. A timestamp error is visible in words 2 and 3 of the very next frame.

// File: rtl/evframe_asm.sv
module evframe_asm #(
  parameter int DEPTH = 16,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic          trig,
  input  logic [7:0]    node_addr,
  input  logic [31:0]   hdr0_cfg,
  input  logic          s_valid,
  input  logic [127:0]  s_ms,
  input  logic [AW-1:0] s_addr,
  input  logic          s_end,
  output logic          o_valid,
  output logic [31:0]   o_data,
  output logic          o_last,
  input  logic          o_ready
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = 12;
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [PW:0] ROOM = (PW+1)'(DEPTH - 4);

  typedef enum logic [1:0] {IDLE, HDR, PAY, TAIL} st_t;

  st_t            st;
  logic [1:0]     hidx;
  logic [63:0]    ts, ts_l;
  logic [7:0]     addr_l;
  logic           coll, have_ref, backup, mism;
  logic [AW-1:0]  ref_addr;
  logic [CW-1:0]  m_cnt, d_cnt;
  logic [31:0]    mem [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [PW:0]    fill;

  wire seen  = coll && s_valid;
  wire fits  = fill <= ROOM;
  wire acc   = seen && fits;
  wire drop  = seen && !fits;
  wire rd    = (st == PAY) && (fill != '0) && o_ready;
  wire start = (st == IDLE) && trig;
  wire [31:0] tail = {4'b0, backup, mism, 2'b0, d_cnt, m_cnt};

  always_ff @(posedge clk) begin
    if (!rst_n || run_start) ts <= '0;
    else                     ts <= ts + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      hidx   <= '0;
      ts_l   <= '0;
      addr_l <= '0;
    end else begin
      case (st)
        IDLE: if (trig) begin
          st     <= HDR;
          hidx   <= '0;
          ts_l   <= ts;
          addr_l <= node_addr;
        end
        HDR: if (o_ready) begin
          hidx <= hidx + 2'd1;
          if (hidx == 2'd3) st <= PAY;
        end
        PAY:  if (!coll && fill == '0) st <= TAIL;
        TAIL: if (o_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coll     <= 1'b0;
      have_ref <= 1'b0;
      backup   <= 1'b0;
      mism     <= 1'b0;
      ref_addr <= '0;
      m_cnt    <= '0;
      d_cnt    <= '0;
    end else if (start) begin
      coll     <= 1'b1;
      have_ref <= 1'b0;
      backup   <= 1'b0;
      mism     <= 1'b0;
      m_cnt    <= '0;
      d_cnt    <= '0;
    end else begin
      if (coll && s_end) coll <= 1'b0;
      if (acc && m_cnt != CMAX) m_cnt <= m_cnt + 1'b1;
      if (drop) begin
        backup <= 1'b1;
        if (d_cnt != CMAX) d_cnt <= d_cnt + 1'b1;
      end
      if (seen) begin
        if (!have_ref) begin
          have_ref <= 1'b1;
          ref_addr <= s_addr;
        end else if (s_addr != ref_addr) begin
          mism <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (acc) wp <= wp + PW'(4);
      if (rd)  rp <= rp + 1'b1;
      fill <= fill + (acc ? (PW+1)'(4) : '0) - (PW+1)'(rd);
    end
  end

  always_ff @(posedge clk) begin
    if (acc)
      for (int i = 0; i < 4; i++)
        mem[wp + PW'(i)] <= s_ms[32*i +: 32];
  end

  assign o_valid = (st == HDR) || (st == TAIL) || (st == PAY && fill != '0);
  assign o_last  = (st == TAIL);

  always_comb begin
    case (st)
      HDR: case (hidx)
        2'd0:    o_data = hdr0_cfg;
        2'd1:    o_data = {24'b0, addr_l};
        2'd2:    o_data = ts_l[31:0];
        default: o_data = ts_l[63:32];
      endcase
      PAY:     o_data = mem[rp];
      TAIL:    o_data = tail;
      default: o_data = '0;
    endcase
  end
endmodule

module evframe_asm_chk #(
  parameter int DEPTH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      o_valid,
  input logic                      o_ready,
  input logic [31:0]               o_data,
  input logic                      o_last,
  input logic [$clog2(DEPTH):0]    fill
);
  a_r12_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last));

  a_r5_idle_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_ready && o_last |=> !o_valid);

  a_r7_drop_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_last |-> (o_data[23:12] == 12'd0 || o_data[27]));

  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_last |-> (o_data[31:28] == 4'd0 && o_data[25:24] == 2'd0));

  a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> !o_valid);
endmodule

bind evframe_asm evframe_asm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
  .o_data(o_data), .o_last(o_last), .fill(fill)
);

// File: tb/tb_evframe_asm.sv
module tb_evframe_asm;
  localparam int PERIOD = 10;
  localparam int NVEC = 6;
  // fields: [31:16] sample count, [15] stall sink, [14:8] mismatching index (7F none), [7:0] address
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_7F11, 32'h0001_7F22, 32'h0003_7F33,
    32'h0006_FF44, 32'h0003_0255, 32'h0005_8466
  };

  logic clk = 1'b0, rst_n = 1'b0, run_start = 1'b0, trig = 1'b0;
  logic [7:0] node_addr = '0;
  logic [31:0] hdr0_cfg = '0;
  logic s_valid = 1'b0, s_end = 1'b0, o_ready = 1'b0;
  logic [127:0] s_ms = '0;
  logic [7:0] s_addr = '0;
  logic o_valid, o_last;
  logic [31:0] o_data;
  logic [63:0] tsm = '0;
  int total = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk)
    if (!rst_n || run_start) tsm <= '0; else tsm <= tsm + 64'd1;

  evframe_asm dut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .trig(trig),
    .node_addr(node_addr), .hdr0_cfg(hdr0_cfg), .s_valid(s_valid),
    .s_ms(s_ms), .s_addr(s_addr), .s_end(s_end), .o_valid(o_valid),
    .o_data(o_data), .o_last(o_last), .o_ready(o_ready)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input int v, input int i, input int j);
    return {8'hC0 ^ 8'(v), 8'(j), 16'(i)};
  endfunction

  task automatic run_event(input int v, input int n, input bit stall, input int bad,
                           input logic [7:0] addr, input bit busy_trig);
    logic [31:0] got [64];
    int cnt = 0, step, em, ed, exp_len;
    logic [63:0] ets = '0;
    bit done = 0, hold_pend = 0, early_last = 0;
    logic [31:0] hold_data = '0;
    step = stall ? 1 : 5;
    em = stall ? (n < 4 ? n : 4) : n;
    ed = stall ? (n > 4 ? n - 4 : 0) : 0;
    if (ed > 4095) ed = 4095;
    exp_len = 5 + 4*em;
    for (int c = 0; c < 20000 && !done; c++) begin
      @(negedge clk);
      trig = (c == 0) || (busy_trig && c == 3);
      node_addr = (c == 0) ? addr : 8'hEE;
      hdr0_cfg = 32'hCF00_0000 | 32'(v);
      s_valid = 1'b0; s_end = 1'b0;
      if (c >= 1 && (c-1) % step == 0 && (c-1)/step < n) begin
        int i = (c-1)/step;
        s_valid = 1'b1;
        s_ms = {sw(v,i,3), sw(v,i,2), sw(v,i,1), sw(v,i,0)};
        s_addr = (i == bad) ? (addr ^ 8'h01) : addr;
      end
      if (c == 1 + step*n) s_end = 1'b1;
      o_ready = stall ? (c > step*n + 1) : (c % 3 != 2);
      #1;
      if (c == 0) ets = tsm;
      if (hold_pend) check(o_valid && o_data == hold_data, "R12 hold", {31'b0, o_valid, o_data}, {32'h1, hold_data});
      hold_pend = o_valid && !o_ready;
      hold_data = o_data;
      if (o_valid && o_ready) begin
        if (cnt < 64) got[cnt] = o_data;
        cnt++;
        if (o_last) done = 1;
        else if (cnt >= exp_len) early_last = 1;
      end
    end
    @(negedge clk);
    trig = 1'b0; s_valid = 1'b0; s_end = 1'b0; o_ready = 1'b1;
    check(done && cnt == exp_len && !early_last, "R5 frame length/last", 64'(cnt), 64'(exp_len));
    if (cnt != exp_len) return;
    check(got[0] == (32'hCF00_0000 | 32'(v)), "R3 word0", 64'(got[0]), 64'(32'hCF00_0000 | 32'(v)));
    check(got[1] == {24'b0, addr}, "R3 word1", 64'(got[1]), 64'({24'b0, addr}));
    check({got[3], got[2]} == ets, "R2 timestamp", {got[3], got[2]}, ets);
    for (int i = 0; i < em; i++)
      for (int j = 0; j < 4; j++)
        check(got[4 + 4*i + j] == sw(v,i,j), "R4 payload", 64'(got[4+4*i+j]), 64'(sw(v,i,j)));
    check(got[cnt-1][11:0] == 12'(em), "R6 sample count", 64'(got[cnt-1][11:0]), 64'(em));
    check(got[cnt-1][23:12] == 12'(ed), "R7 R8 drop count", 64'(got[cnt-1][23:12]), 64'(ed));
    check(got[cnt-1][27] == (ed > 0), "R7 backup flag", 64'(got[cnt-1][27]), 64'(ed > 0));
    check(got[cnt-1][26] == (bad < n), "R9 address mismatch", 64'(got[cnt-1][26]), 64'(bad < n));
    check(got[cnt-1][31:28] == 4'd0 && got[cnt-1][25:24] == 2'd0, "R10 zero bits",
          64'(got[cnt-1]), 64'(got[cnt-1] & 32'h0CFF_FFFF));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R5 watchdog: actual=no end expected=end");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check(!o_valid, "R1 valid in reset", 64'(o_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    #1 check(!o_valid, "R1 valid after reset", 64'(o_valid), 64'd0);
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    repeat (7) @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_event(v, int'(VEC[v][31:16]), VEC[v][15], int'(VEC[v][14:8]), VEC[v][7:0], 1'b0);

    // R8: saturation of the drop count
    run_event(6, 4100, 1'b1, 127, 8'h77, 1'b0);

    // R11: trigger while busy is ignored
    run_event(7, 2, 1'b0, 127, 8'h88, 1'b1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      check(!o_valid, "R11 busy trigger ignored", 64'(o_valid), 64'd0);
    end

    // R11: samples and end outside a window are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      s_valid = 1'b1; s_end = 1'b1; s_addr = 8'h99; s_ms = '1;
      #1 check(!o_valid, "R11 idle samples ignored", 64'(o_valid), 64'd0);
    end
    @(negedge clk); s_valid = 1'b0; s_end = 1'b0;
    run_event(9, 0, 1'b0, 127, 8'h44, 1'b0);

    // R2: new run restarts the timestamp
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    run_event(10, 1, 1'b0, 127, 8'h5A, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule